// File: doc/BRIEF.md
# Y86-64 Instruction Fetch and Length Decoder

This block sits at the front of a Y86-64 processor. Each cycle it is given the program counter and a window of ten instruction bytes that begins at that address. It splits the opcode byte into its instruction code and function code, works out whether a register-specifier byte and an eight-byte constant follow, extracts the register fields and the constant, and forms the fall-through address. It also flags opcodes that do not exist and the halt instruction.

The result is registered once. A window presented with `in_valid` high appears on the outputs one cycle later with `out_valid` high, and every field of that instruction (including halt and invalid) appears in the same cycle. The surrounding control uses `halt_o` to freeze the PC. It uses `valp_o` as the next sequential fetch address. The window is little-endian: byte k of the instruction sits at bits [8k+7:8k] of `win_i`.

Top module: `y86_fetch_decode`

## Requirements
- R1: One cycle after a clock edge where `in_valid` is high, `icode_o` equals bits [7:4] of window byte 0 and `ifun_o` equals bits [3:0] of that byte.
- R2: For a legal opcode, `need_regids_o` is 1 for instruction codes 0x2, 0x3, 0x4, 0x5, 0x6, 0xA and 0xB, and `need_valc_o` is 1 for codes 0x3, 0x4, 0x5, 0x7 and 0x8. Otherwise each is 0.
- R3: When a register byte is present, `ra_o` is the high nibble of window byte 1 and `rb_o` is its low nibble. When no register byte is present, both are 0xF.
- R4: When a constant is present, `valc_o` is the little-endian 64-bit value in window bytes 2..9 if a register byte is present, and in bytes 1..8 if it is not. Without a constant, `valc_o` is 0.
- R5: `valp_o` equals the PC plus 1, plus 1 if a register byte is present, plus 8 if a constant is present. The sum wraps modulo 2^64.
- R6: `invalid_o` is 1 when the instruction code is above 0xB, or when the function code is out of range for its code. The range is 0..6 for codes 0x2 and 0x7, 0..3 for code 0x6, and exactly 0 for every other code. An invalid opcode also forces both need flags to 0, `halt_o` to 0, `ra_o`/`rb_o` to 0xF, `valc_o` to 0 and `valp_o` to PC+1.
- R7: `halt_o` is 1 exactly when window byte 0 is 0x00, and it appears in the same cycle as that instruction's other fields.
- R8: While reset is asserted, every output is 0. After a cycle with `in_valid` low, `out_valid` is 0 and every decoded field keeps its previous value.
- R9: `out_valid` is `in_valid` delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Window and PC are valid this cycle |
| pc_i | input | 64 | Address of window byte 0 |
| win_i | input | 80 | Instruction bytes, byte k at bits [8k+7:8k] |
| out_valid | output | 1 | Decoded fields are valid |
| icode_o | output | 4 | Instruction code |
| ifun_o | output | 4 | Function code |
| ra_o | output | 4 | First register field, 0xF if absent |
| rb_o | output | 4 | Second register field, 0xF if absent |
| valc_o | output | 64 | Constant or displacement |
| valp_o | output | 64 | Fall-through address |
| need_regids_o | output | 1 | A register byte follows the opcode |
| need_valc_o | output | 1 | An eight-byte constant follows |
| halt_o | output | 1 | Instruction is halt |
| invalid_o | output | 1 | Opcode is not legal |

## Verification
All 256 opcode bytes are swept with several tail patterns and PC values. Every function code at the edge of its legal range is therefore seen. A decoder with an off-by-one range limit would call a legal conditional move or jump illegal, or accept a fifth ALU function. The constant's start position is checked against the register-byte rule. A design that always took the constant from byte 1 would return a value shifted by one byte for irmovq, rmmovq and mrmovq. Wrap of the fall-through address near the top of memory, zeroed fields on illegal opcodes, halt against a nonzero function code, and field hold while idle are each checked explicitly.

// File: rtl/y86f_pkg.sv
package y86f_pkg;
    localparam logic [3:0] IC_HALT  = 4'h0;
    localparam logic [3:0] IC_NOP   = 4'h1;
    localparam logic [3:0] IC_CMOV  = 4'h2;
    localparam logic [3:0] IC_IRMOV = 4'h3;
    localparam logic [3:0] IC_RMMOV = 4'h4;
    localparam logic [3:0] IC_MRMOV = 4'h5;
    localparam logic [3:0] IC_ALU   = 4'h6;
    localparam logic [3:0] IC_JUMP  = 4'h7;
    localparam logic [3:0] IC_CALL  = 4'h8;
    localparam logic [3:0] IC_RET   = 4'h9;
    localparam logic [3:0] IC_PUSH  = 4'hA;
    localparam logic [3:0] IC_POP   = 4'hB;

    localparam logic [3:0] FN_COND_MAX = 4'h6;
    localparam logic [3:0] FN_ALU_MAX  = 4'h3;
    localparam logic [3:0] REG_NONE    = 4'hF;
endpackage

// File: rtl/y86f_opclass.sv
module y86f_opclass
    import y86f_pkg::*;
(
    input  logic [7:0] op_byte,
    output logic       need_reg,
    output logic       need_cst,
    output logic       is_halt,
    output logic       is_bad
);
    logic [3:0] code;
    logic [3:0] func;
    logic       func_ok;
    logic       reg_raw;
    logic       cst_raw;

    always_comb begin
        code    = op_byte[7:4];
        func    = op_byte[3:0];
        func_ok = 1'b0;
        reg_raw = 1'b0;
        cst_raw = 1'b0;
        case (code)
            IC_HALT, IC_NOP, IC_RET: begin
                func_ok = (func == 4'h0);
            end
            IC_CMOV: begin
                func_ok = (func <= FN_COND_MAX);
                reg_raw = 1'b1;
            end
            IC_IRMOV, IC_RMMOV, IC_MRMOV: begin
                func_ok = (func == 4'h0);
                reg_raw = 1'b1;
                cst_raw = 1'b1;
            end
            IC_ALU: begin
                func_ok = (func <= FN_ALU_MAX);
                reg_raw = 1'b1;
            end
            IC_JUMP: begin
                func_ok = (func <= FN_COND_MAX);
                cst_raw = 1'b1;
            end
            IC_CALL: begin
                func_ok = (func == 4'h0);
                cst_raw = 1'b1;
            end
            IC_PUSH, IC_POP: begin
                func_ok = (func == 4'h0);
                reg_raw = 1'b1;
            end
            default: begin
                func_ok = 1'b0;
            end
        endcase
        is_bad   = !func_ok;
        need_reg = reg_raw && func_ok;
        need_cst = cst_raw && func_ok;
        is_halt  = func_ok && (code == IC_HALT);
    end
endmodule

// File: rtl/y86f_field_pick.sv
module y86f_field_pick
    import y86f_pkg::*;
#(
    parameter int CONST_BYTES = 8,
    localparam int WORD_W     = 8 * CONST_BYTES,
    localparam int TAIL_W     = 8 * (CONST_BYTES + 1)
) (
    input  logic [TAIL_W-1:0] tail,
    input  logic              need_reg,
    input  logic              need_cst,
    output logic [3:0]        reg_a,
    output logic [3:0]        reg_b,
    output logic [WORD_W-1:0] const_val
);
    logic [WORD_W-1:0] from_b1;
    logic [WORD_W-1:0] from_b2;

    generate
        for (genvar k = 0; k < CONST_BYTES; k++) begin : g_lane
            assign from_b1[8*k +: 8] = tail[8*k +: 8];
            if (k < CONST_BYTES - 1) begin : g_inner
                assign from_b2[8*k +: 8] = tail[8*(k+1) +: 8];
            end else begin : g_last
                assign from_b2[8*k +: 8] = tail[TAIL_W-1 -: 8];
            end
        end
    endgenerate

    always_comb begin
        reg_a     = need_reg ? tail[7:4] : REG_NONE;
        reg_b     = need_reg ? tail[3:0] : REG_NONE;
        const_val = '0;
        if (need_cst) begin
            const_val = need_reg ? from_b2 : from_b1;
        end
    end
endmodule

// File: rtl/y86f_pc_step.sv
module y86f_pc_step #(
    parameter int ADDR_W      = 64,
    parameter int CONST_BYTES = 8,
    localparam int LEN_W      = $clog2(CONST_BYTES + 3)
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic              need_reg,
    input  logic              need_cst,
    output logic [ADDR_W-1:0] next_pc
);
    logic [LEN_W-1:0] ilen;

    always_comb begin
        ilen = LEN_W'(1);
        if (need_reg) ilen = ilen + LEN_W'(1);
        if (need_cst) ilen = ilen + LEN_W'(CONST_BYTES);
        next_pc = pc + ADDR_W'(ilen);
    end
endmodule

// File: rtl/y86_fetch_decode.sv
module y86_fetch_decode
    import y86f_pkg::*;
#(
    parameter int ADDR_W      = 64,
    parameter int CONST_BYTES = 8,
    localparam int WORD_W     = 8 * CONST_BYTES,
    localparam int WIN_BYTES  = CONST_BYTES + 2,
    localparam int WIN_W      = 8 * WIN_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [WIN_W-1:0]  win_i,
    output logic              out_valid,
    output logic [3:0]        icode_o,
    output logic [3:0]        ifun_o,
    output logic [3:0]        ra_o,
    output logic [3:0]        rb_o,
    output logic [WORD_W-1:0] valc_o,
    output logic [ADDR_W-1:0] valp_o,
    output logic              need_regids_o,
    output logic              need_valc_o,
    output logic              halt_o,
    output logic              invalid_o
);
    typedef struct packed {
        logic              valid;
        logic [3:0]        icode;
        logic [3:0]        ifun;
        logic [3:0]        ra;
        logic [3:0]        rb;
        logic [WORD_W-1:0] valc;
        logic [ADDR_W-1:0] valp;
        logic              need_reg;
        logic              need_cst;
        logic              halt;
        logic              bad;
    } stage_t;

    stage_t stage_d;
    stage_t stage_q;

    logic              dec_need_reg;
    logic              dec_need_cst;
    logic              dec_halt;
    logic              dec_bad;
    logic [3:0]        dec_ra;
    logic [3:0]        dec_rb;
    logic [WORD_W-1:0] dec_valc;
    logic [ADDR_W-1:0] dec_valp;

    y86f_opclass u_opclass (
        .op_byte  (win_i[7:0]),
        .need_reg (dec_need_reg),
        .need_cst (dec_need_cst),
        .is_halt  (dec_halt),
        .is_bad   (dec_bad)
    );

    y86f_field_pick #(
        .CONST_BYTES (CONST_BYTES)
    ) u_field_pick (
        .tail      (win_i[WIN_W-1:8]),
        .need_reg  (dec_need_reg),
        .need_cst  (dec_need_cst),
        .reg_a     (dec_ra),
        .reg_b     (dec_rb),
        .const_val (dec_valc)
    );

    y86f_pc_step #(
        .ADDR_W      (ADDR_W),
        .CONST_BYTES (CONST_BYTES)
    ) u_pc_step (
        .pc       (pc_i),
        .need_reg (dec_need_reg),
        .need_cst (dec_need_cst),
        .next_pc  (dec_valp)
    );

    always_comb begin
        stage_d       = stage_q;
        stage_d.valid = in_valid;
        if (in_valid) begin
            stage_d.icode    = win_i[7:4];
            stage_d.ifun     = win_i[3:0];
            stage_d.ra       = dec_ra;
            stage_d.rb       = dec_rb;
            stage_d.valc     = dec_valc;
            stage_d.valp     = dec_valp;
            stage_d.need_reg = dec_need_reg;
            stage_d.need_cst = dec_need_cst;
            stage_d.halt     = dec_halt;
            stage_d.bad      = dec_bad;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign out_valid     = stage_q.valid;
    assign icode_o       = stage_q.icode;
    assign ifun_o        = stage_q.ifun;
    assign ra_o          = stage_q.ra;
    assign rb_o          = stage_q.rb;
    assign valc_o        = stage_q.valc;
    assign valp_o        = stage_q.valp;
    assign need_regids_o = stage_q.need_reg;
    assign need_valc_o   = stage_q.need_cst;
    assign halt_o        = stage_q.halt;
    assign invalid_o     = stage_q.bad;

    AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid))); // R9

    AST_VALP_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (valp_o - $past(pc_i) ==
            ADDR_W'(1 + (need_regids_o ? 1 : 0) + (need_valc_o ? CONST_BYTES : 0)))); // R5

    AST_HALT_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o |-> (icode_o == IC_HALT && ifun_o == 4'h0 && !invalid_o)); // R7

    AST_BAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        invalid_o |-> (!need_regids_o && !need_valc_o && !halt_o)); // R6

    AST_NOREG_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !need_regids_o) |-> (ra_o == REG_NONE && rb_o == REG_NONE)); // R3

    AST_NOCONST_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !need_valc_o) |-> (valc_o == '0)); // R4

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(in_valid)) |-> ($stable(valp_o) && $stable(valc_o) && $stable(icode_o))); // R8

    AST_CODE_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ({icode_o, ifun_o} == $past(win_i[7:0]))); // R1
endmodule

// File: tb/y86_fetch_decode_tb.sv
`timescale 1ns/1ps
module y86_fetch_decode_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] pc_i = '0;
    logic [79:0] win_i = '0;
    logic        out_valid;
    logic [3:0]  icode_o, ifun_o, ra_o, rb_o;
    logic [63:0] valc_o, valp_o;
    logic        need_regids_o, need_valc_o, halt_o, invalid_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    y86_fetch_decode u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pc_i(pc_i), .win_i(win_i),
        .out_valid(out_valid), .icode_o(icode_o), .ifun_o(ifun_o), .ra_o(ra_o), .rb_o(rb_o),
        .valc_o(valc_o), .valp_o(valp_o), .need_regids_o(need_regids_o),
        .need_valc_o(need_valc_o), .halt_o(halt_o), .invalid_o(invalid_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    logic        e_reg, e_cst, e_bad, e_halt;
    logic [3:0]  e_ra, e_rb;
    logic [63:0] e_valc, e_valp;

    function automatic void predict(input logic [79:0] w, input logic [63:0] pc);
        logic [3:0] ic;
        logic [3:0] fn;
        bit legal;
        bit has_r;
        bit has_c;
        ic = w[7:4];
        fn = w[3:0];
        legal = 0; has_r = 0; has_c = 0;
        if (ic == 4'h2 || ic == 4'h7) legal = (fn < 7);
        else if (ic == 4'h6) legal = (fn < 4);
        else if (ic < 4'hC) legal = (fn == 0);
        if (legal) begin
            has_r = (ic >= 4'h2 && ic <= 4'h6) || ic == 4'hA || ic == 4'hB;
            has_c = (ic >= 4'h3 && ic <= 4'h5) || ic == 4'h7 || ic == 4'h8;
        end
        e_bad  = !legal;
        e_reg  = has_r;
        e_cst  = has_c;
        e_halt = (w[7:0] == 8'h00);
        e_ra   = has_r ? w[15:12] : 4'hF;
        e_rb   = has_r ? w[11:8]  : 4'hF;
        e_valc = !has_c ? 64'd0 : (has_r ? w[79:16] : w[71:8]);
        e_valp = pc + 64'd1 + (has_r ? 64'd1 : 64'd0) + (has_c ? 64'd8 : 64'd0);
    endfunction

    task automatic apply_and_check(input logic [63:0] pc, input logic [79:0] w);
        predict(w, pc);
        @(negedge clk);
        in_valid = 1'b1; pc_i = pc; win_i = w;
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid === 1'b1, "R9 out_valid after in_valid", 64'(out_valid), 64'd1);
        chk({icode_o, ifun_o} === w[7:0], "R1 icode/ifun", 64'({icode_o, ifun_o}), 64'(w[7:0]));
        chk({need_regids_o, need_valc_o} === {e_reg, e_cst}, "R2 need flags",
            64'({need_regids_o, need_valc_o}), 64'({e_reg, e_cst}));
        chk({ra_o, rb_o} === {e_ra, e_rb}, "R3 register fields", 64'({ra_o, rb_o}), 64'({e_ra, e_rb}));
        chk(valc_o === e_valc, "R4 valC", valc_o, e_valc);
        chk(valp_o === e_valp, "R5 valP", valp_o, e_valp);
        chk(invalid_o === e_bad, "R6 invalid", 64'(invalid_o), 64'(e_bad));
        chk(halt_o === e_halt, "R7 halt", 64'(halt_o), 64'(e_halt));
    endtask

    task automatic idle_check();
        logic [63:0] old_p;
        logic [63:0] old_c;
        old_p = valp_o; old_c = valc_o;
        pc_i = 64'h1234_5678_9ABC_DEF0; win_i = {10{8'h5A}};
        @(negedge clk);
        chk(out_valid === 1'b0, "R8 out_valid low when idle", 64'(out_valid), 64'd0);
        chk(valp_o === old_p && valc_o === old_c, "R8 fields held when idle", valp_o, old_p);
    endtask

    function automatic logic [79:0] mk_win(input logic [7:0] op, input int pat);
        logic [79:0] w;
        w[7:0] = op;
        for (int k = 1; k < 10; k++) begin
            case (pat)
                0: w[8*k +: 8] = 8'(k * 8'h11 + 8'h01);
                1: w[8*k +: 8] = 8'hFF;
                default: w[8*k +: 8] = 8'(k * 37 + 5);
            endcase
        end
        return w;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        in_valid = 1'b1;
        win_i = 80'h30F0;
        pc_i = 64'h40;
        repeat (3) @(negedge clk);
        chk(out_valid === 1'b0 && valp_o === 64'd0 && icode_o === 4'd0 && halt_o === 1'b0,
            "R8 reset state", valp_o, 64'd0);
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid === 1'b0, "R9 no valid without input", 64'(out_valid), 64'd0);

        apply_and_check(64'h0, {64'd1, 8'hF0, 8'h30});
        chk(valc_o === 64'd1 && ra_o === 4'hF && rb_o === 4'h0, "R4 irmovq example", valc_o, 64'd1);
        apply_and_check(64'h22, {8'h00, 64'h0A, 8'h74});
        chk(valc_o === 64'h0A && valp_o === 64'h2B, "R5 jne example", valp_o, 64'h2B);
        apply_and_check(64'h1E, {64'd0, 8'h12, 8'h60});
        chk(valp_o === 64'h20 && ra_o === 4'h1 && rb_o === 4'h2, "R3 addq example", valp_o, 64'h20);
        apply_and_check(64'h14, {64'd0, 8'h23, 8'h40});
        chk(valp_o === 64'h1E, "R5 rmmovq length 10", valp_o, 64'h1E);
        apply_and_check(64'h2B, 80'h0);
        chk(halt_o === 1'b1, "R7 halt byte", 64'(halt_o), 64'd1);
        apply_and_check(64'h10, 80'h05);
        chk(halt_o === 1'b0 && invalid_o === 1'b1, "R6 halt code with nonzero function", 64'(invalid_o), 64'd1);
        apply_and_check(64'hFFFF_FFFF_FFFF_FFFA, {64'h1122_3344_5566_7788, 8'h45, 8'h50});
        chk(valp_o === 64'h4, "R5 valP wraps", valp_o, 64'h4);
        idle_check();

        for (int op = 0; op < 256; op++) begin
            for (int pat = 0; pat < 3; pat++) begin
                apply_and_check(64'(op * 97 + pat * 4099), mk_win(8'(op), pat));
                if ((op % 16) == pat) idle_check();
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule